// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This unit performs the shift and rotate family of integer operations on 8-, 16- or 32-bit operands. A size input picks the active width, and an operation code picks one of nine functions: shift left, shift right with zero fill, shift right with sign fill, rotate left or right, rotate left or right through the carry flag, and two funnel shifts. A funnel shift moves the destination and fills the vacated positions from a second source operand. The result, the new carry flag and a carry-written indication are registered. They appear one clock after the inputs are presented.

A count of zero after masking is a no-op. The destination passes through, the carry is kept and the carry-written output stays low. An upstream execution stage supplies both operands, the count and the current carry. It takes the registered outputs back into its register file and flag state.

Top module: `srot_unit`

## Requirements
- R1: After reset, `res_o`, `cf_o` and `cf_upd_o` are 0. Any later input set appears on the outputs exactly one clock edge after it is sampled.
- R2: Only bits [4:0] of `cnt_i` are used. When those bits are zero, the result is the size-masked destination, `cf_o` equals `cf_i` and `cf_upd_o` is 0.
- R3: `size_i` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the active width are ignored, and result bits above it are 0.
- R4: Code 0 shifts left and fills with zeros. Code 9 behaves exactly like code 0. Code 1 shifts right and fills with zeros. The carry is the last bit shifted out, which is 0 once the count exceeds the width.
- R5: Code 2 shifts right and fills with copies of the sign bit. The carry is the last bit shifted out, which is the sign bit once the count reaches the width.
- R6: Code 3 rotates left and code 4 rotates right, so no bits are lost. The carry is the last bit rotated out. After a left rotate this is the new bit 0, and after a right rotate it is the new top bit.
- R7: Code 5 rotates left and code 6 rotates right through the carry, over a ring of width+1 bits. On a left rotate the carry enters bit 0 and the old top bit becomes the carry. A right rotate is the mirror image.
- R8: Code 7 shifts the destination left and fills the low positions with the top bits of the source. Zeros follow once the source is used up. The carry is the last destination-or-source bit shifted out.
- R9: Code 8 shifts the destination right and fills the high positions with the low bits of the source. Zeros follow once the source is used up. The carry is the last bit shifted out.
- R10: Codes 10 to 15 are no-ops. The result is the size-masked destination, `cf_o` equals `cf_i` and `cf_upd_o` is 0.
- R11: `cf_upd_o` is 1 exactly when the code is 0 to 9 and the masked count is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand width select |
| cnt_i | input | 8 | Shift or rotate count, low 5 bits used |
| cf_i | input | 1 | Incoming carry flag |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Fill source for the funnel shifts |
| res_o | output | 32 | Registered result |
| cf_o | output | 1 | Registered carry flag |
| cf_upd_o | output | 1 | Registered flag: carry was written |

## Verification
The outputs are a single register stage with no state carried between operations. Any corruption inside the unit therefore shows on `res_o`, `cf_o` or `cf_upd_o` on the clock edge right after the affected vector. A fault cannot stay hidden for more than one cycle. Some faults show only for certain inputs: a wrong ring length in the through-carry rotates, a wrong masking of the count, or a lost sign fill. These show only when the count passes the active width or wraps modulo width+1. The stimulus therefore sweeps counts across the whole 0..255 range for every size.

// File: rtl/srot_pkg.sv
package srot_pkg;

    localparam logic [3:0] SR_SHL  = 4'd0;
    localparam logic [3:0] SR_SHR  = 4'd1;
    localparam logic [3:0] SR_SAR  = 4'd2;
    localparam logic [3:0] SR_ROL  = 4'd3;
    localparam logic [3:0] SR_ROR  = 4'd4;
    localparam logic [3:0] SR_RCL  = 4'd5;
    localparam logic [3:0] SR_RCR  = 4'd6;
    localparam logic [3:0] SR_DSHL = 4'd7;
    localparam logic [3:0] SR_DSHR = 4'd8;
    localparam logic [3:0] SR_SAL  = 4'd9;

    localparam logic [1:0] SZ_B = 2'd0;
    localparam logic [1:0] SZ_H = 2'd1;
    localparam logic [1:0] SZ_W = 2'd2;

    typedef struct packed {
        logic [31:0] res;
        logic        cf;
        logic        upd;
    } srot_out_t;

endpackage

// File: rtl/srot_size_dec.sv
module srot_size_dec #(
    parameter int DATA_W = 32,
    localparam int WID_W = $clog2(DATA_W) + 2
) (
    input  logic [1:0]        size,
    output logic [WID_W-1:0]  width,
    output logic [DATA_W-1:0] mask
);
    import srot_pkg::*;

    localparam int WIDE_W = 2 * DATA_W;

    logic [WIDE_W-1:0] wide_one;

    always_comb begin
        case (size)
            SZ_B:    width = WID_W'(8);
            SZ_H:    width = WID_W'(16);
            default: width = WID_W'(DATA_W);
        endcase
        wide_one = (WIDE_W'(1) << width) - WIDE_W'(1);
        mask     = DATA_W'(wide_one);
    end

endmodule

// File: rtl/srot_core.sv
module srot_core #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5,
    localparam int WID_W = $clog2(DATA_W) + 2
) (
    input  logic [3:0]        op,
    input  logic [WID_W-1:0]  width,
    input  logic [DATA_W-1:0] mask,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cf_in,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] res,
    output logic              cf_out,
    output logic              upd
);
    import srot_pkg::*;

    localparam int WIDE_W = 2 * DATA_W;
    localparam int RED_STEPS = (1 << CNT_W) / 9 + 1;

    logic [WIDE_W-1:0] wmask, rmask, dw, sw, sx, pair_l, pair_r, rc_v;
    logic [WIDE_W-1:0] t_now, t_last;
    logic [CNT_W-1:0]  cm1;
    logic [WID_W-1:0]  rr, rk, rc_len;

    always_comb begin
        wmask  = WIDE_W'(mask);
        rc_len = width + WID_W'(1);
        rmask  = (WIDE_W'(1) << rc_len) - WIDE_W'(1);
        dw     = WIDE_W'(dst & mask);
        sw     = WIDE_W'(src & mask);
        sx     = dw[width - WID_W'(1)] ? (dw | ~wmask) : dw;
        pair_l = (dw << width) | sw;
        pair_r = (sw << width) | dw;
        rc_v   = dw | (WIDE_W'(cf_in) << width);
        cm1    = cnt - CNT_W'(1);
        rr     = WID_W'(cnt) & (width - WID_W'(1));
        rk     = WID_W'(cnt);
        for (int i = 0; i < RED_STEPS; i++) begin
            if (rk >= rc_len) rk = rk - rc_len;
        end

        t_now  = dw;
        t_last = '0;
        res    = DATA_W'(dw);
        cf_out = cf_in;
        upd    = 1'b0;

        if (cnt != '0) begin
            upd = 1'b1;
            case (op)
                SR_SHL, SR_SAL: begin
                    t_now  = dw << cnt;
                    t_last = dw << cm1;
                    res    = DATA_W'(t_now & wmask);
                    cf_out = t_last[width - WID_W'(1)];
                end
                SR_SHR: begin
                    t_now  = dw >> cnt;
                    t_last = dw >> cm1;
                    res    = DATA_W'(t_now);
                    cf_out = t_last[0];
                end
                SR_SAR: begin
                    t_now  = sx >> cnt;
                    t_last = sx >> cm1;
                    res    = DATA_W'(t_now & wmask);
                    cf_out = t_last[0];
                end
                SR_ROL: begin
                    t_now  = ((dw << rr) | (dw >> (width - rr))) & wmask;
                    res    = DATA_W'(t_now);
                    cf_out = t_now[0];
                end
                SR_ROR: begin
                    t_now  = ((dw >> rr) | (dw << (width - rr))) & wmask;
                    res    = DATA_W'(t_now);
                    cf_out = t_now[width - WID_W'(1)];
                end
                SR_RCL: begin
                    t_now  = ((rc_v << rk) | (rc_v >> (rc_len - rk))) & rmask;
                    res    = DATA_W'(t_now & wmask);
                    cf_out = t_now[width];
                end
                SR_RCR: begin
                    t_now  = ((rc_v >> rk) | (rc_v << (rc_len - rk))) & rmask;
                    res    = DATA_W'(t_now & wmask);
                    cf_out = t_now[width];
                end
                SR_DSHL: begin
                    t_now  = (pair_l << cnt) >> width;
                    t_last = pair_l << cm1;
                    res    = DATA_W'(t_now & wmask);
                    cf_out = t_last[2 * width - 1];
                end
                SR_DSHR: begin
                    t_now  = pair_r >> cnt;
                    t_last = pair_r >> cm1;
                    res    = DATA_W'(t_now & wmask);
                    cf_out = t_last[0];
                end
                default: begin
                    upd = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/srot_unit.sv
module srot_unit #(
    parameter int DATA_W = 32,
    parameter int CNT_IN_W = 8,
    localparam int CNT_W = $clog2(DATA_W),
    localparam int WID_W = $clog2(DATA_W) + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          op_i,
    input  logic [1:0]          size_i,
    input  logic [CNT_IN_W-1:0] cnt_i,
    input  logic                cf_i,
    input  logic [DATA_W-1:0]   dst_i,
    input  logic [DATA_W-1:0]   src_i,
    output logic [DATA_W-1:0]   res_o,
    output logic                cf_o,
    output logic                cf_upd_o
);
    import srot_pkg::*;

    logic [WID_W-1:0]  width;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] core_res;
    logic              core_cf, core_upd;
    logic [CNT_W-1:0]  cnt_m;
    logic              unused_cnt_hi;

    srot_out_t st_d, st_q;

    assign cnt_m         = cnt_i[CNT_W-1:0];
    assign unused_cnt_hi = ^cnt_i[CNT_IN_W-1:CNT_W];

    srot_size_dec #(.DATA_W(DATA_W)) u_dec (
        .size  (size_i),
        .width (width),
        .mask  (mask)
    );

    srot_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .op     (op_i),
        .width  (width),
        .mask   (mask),
        .cnt    (cnt_m),
        .cf_in  (cf_i),
        .dst    (dst_i),
        .src    (src_i),
        .res    (core_res),
        .cf_out (core_cf),
        .upd    (core_upd)
    );

    always_comb begin
        st_d     = '0;
        st_d.res = 32'(core_res);
        st_d.cf  = core_cf;
        st_d.upd = core_upd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o    = DATA_W'(st_q.res);
    assign cf_o     = st_q.cf;
    assign cf_upd_o = st_q.upd;

    // R2: zero masked count keeps the carry and leaves it unwritten
    a_r2_zero_cnt_keeps_cf: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i[CNT_W-1:0] == '0) |=> (!cf_upd_o && cf_o == $past(cf_i)));

    // R3: byte size clears every result bit above bit 7
    a_r3_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_B) |=> (res_o[DATA_W-1:8] == '0));

    // R5: full-width sign fill keeps the sign bit
    a_r5_sar_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SR_SAR && size_i == SZ_W) |=> (res_o[DATA_W-1] == $past(dst_i[DATA_W-1])));

    // R6: full-width rotates lose no bits
    a_r6_rot_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == SR_ROL || op_i == SR_ROR) && size_i == SZ_W)
        |=> ($countones(res_o) == $countones($past(dst_i))));

    // R7: rotates through carry preserve the ones count of carry and operand
    a_r7_rcx_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == SR_RCL || op_i == SR_RCR) && size_i == SZ_W)
        |=> ($countones({cf_o, res_o}) == $countones({$past(cf_i), $past(dst_i)})));

    // R10: undefined codes never write the carry
    a_r10_undef_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > SR_SAL) |=> (!cf_upd_o && cf_o == $past(cf_i)));

endmodule

// File: tb/sim_srot_unit.sv
module sim_srot_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  sz = '0;
    logic [7:0]  cnt = '0;
    logic        cfi = 1'b0;
    logic [31:0] dst = '0;
    logic [31:0] src = '0;
    logic [31:0] res_o;
    logic        cf_o, cf_upd_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    bit          pend = 0;
    logic [31:0] e_res;
    logic        e_cf, e_upd;
    string       e_tag;

    always #2 clk = ~clk;

    srot_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .size_i(sz), .cnt_i(cnt), .cf_i(cfi),
        .dst_i(dst), .src_i(src), .res_o(res_o), .cf_o(cf_o), .cf_upd_o(cf_upd_o)
    );

    // Step-by-step behavioural model: one bit position per iteration
    function automatic void ref_op(input logic [3:0] o, input logic [1:0] s,
                                   input logic [31:0] d, input logic [31:0] f,
                                   input logic [7:0] c8, input logic ci,
                                   output logic [31:0] r, output logic co, output logic up);
        int n = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
        logic [31:0] m = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
        logic [31:0] x = d & m;
        logic [31:0] y = f & m;
        int c = c8 % 32;
        logic t;
        co = ci;
        up = 1'b0;
        if (o <= 4'd9 && c != 0) begin
            up = 1'b1;
            for (int i = 0; i < c; i++) begin
                case (o)
                    4'd0, 4'd9: begin co = x[n-1]; x = (x << 1) & m; end
                    4'd1: begin co = x[0]; x = x >> 1; end
                    4'd2: begin co = x[0]; x = (x >> 1) | ({31'b0, x[n-1]} << (n-1)); end
                    4'd3: begin co = x[n-1]; x = ((x << 1) | {31'b0, co}) & m; end
                    4'd4: begin co = x[0]; x = (x >> 1) | ({31'b0, co} << (n-1)); end
                    4'd5: begin t = x[n-1]; x = ((x << 1) | {31'b0, co}) & m; co = t; end
                    4'd6: begin t = x[0]; x = (x >> 1) | ({31'b0, co} << (n-1)); co = t; end
                    4'd7: begin co = x[n-1]; x = ((x << 1) | {31'b0, y[n-1]}) & m; y = (y << 1) & m; end
                    default: begin co = x[0]; x = (x >> 1) | ({31'b0, y[0]} << (n-1)); y = y >> 1; end
                endcase
            end
        end
        r = x;
    endfunction

    function automatic string tag_of(input logic [3:0] o, input logic [1:0] s, input logic [7:0] c8);
        if (s == 2'd3)        return "R3";
        if (c8[4:0] == 5'd0)  return "R2";
        case (o)
            4'd0, 4'd1, 4'd9: return "R4";
            4'd2:             return "R5";
            4'd3, 4'd4:       return "R6";
            4'd5, 4'd6:       return "R7";
            4'd7:             return "R8";
            4'd8:             return "R9";
            default:          return "R10";
        endcase
    endfunction

    task automatic compare();
        n_chk += 3;
        if (res_o !== e_res) begin
            n_bad++;
            $display("FAIL %s result: actual=%h expected=%h", e_tag, res_o, e_res);
        end
        if (cf_o !== e_cf) begin
            n_bad++;
            $display("FAIL %s carry: actual=%b expected=%b", e_tag, cf_o, e_cf);
        end
        if (cf_upd_o !== e_upd) begin
            n_bad++;
            $display("FAIL R11 carry-written: actual=%b expected=%b", cf_upd_o, e_upd);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [1:0] s, input logic [31:0] d,
                         input logic [31:0] f, input logic [7:0] c8, input logic ci);
        @(negedge clk);
        if (pend) compare();
        op = o; sz = s; dst = d; src = f; cnt = c8; cfi = ci;
        ref_op(o, s, d, f, c8, ci, e_res, e_cf, e_upd);
        e_tag = tag_of(o, s, c8);
        pend = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_chk++;
        if (res_o !== '0 || cf_o !== 1'b0 || cf_upd_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual=%h/%b/%b expected=0/0/0", res_o, cf_o, cf_upd_o);
        end
        // directed byte vectors (R4 R5 R6 R7)
        apply(4'd1, 2'd0, 32'h6B, 0, 8'd1, 0);
        apply(4'd0, 2'd0, 32'h35, 0, 8'd3, 0);
        apply(4'd2, 2'd0, 32'h8C, 0, 8'd1, 0);
        apply(4'd2, 2'd0, 32'hC6, 0, 8'd3, 0);
        apply(4'd4, 2'd0, 32'h6B, 0, 8'd1, 0);
        apply(4'd3, 2'd0, 32'hB5, 0, 8'd3, 0);
        apply(4'd3, 2'd0, 32'h3F, 0, 8'd4, 0);
        apply(4'd4, 2'd0, 32'h3F, 0, 8'd4, 0);
        apply(4'd5, 2'd0, 32'h88, 0, 8'd1, 0);
        apply(4'd5, 2'd0, 32'h10, 0, 8'd1, 1);
        apply(4'd6, 2'd0, 32'h10, 0, 8'd1, 1);
        apply(4'd6, 2'd0, 32'h6B, 0, 8'd1, 1);
        apply(4'd5, 2'd0, 32'hB5, 0, 8'd3, 1);
        // directed funnel vectors (R8 R9)
        apply(4'd7, 2'd1, 32'h9BA6, 32'hAC36, 8'd4, 0);
        apply(4'd8, 2'd1, 32'h234B, 32'h7654, 8'd4, 0);
        apply(4'd7, 2'd1, 32'h9FA6, 32'h7C36, 8'd4, 0);
        apply(4'd8, 2'd1, 32'hFA67, 32'h7C36, 8'd8, 0);
        // count masking and zero count (R2), width overrun, undefined codes (R10)
        apply(4'd0, 2'd2, 32'h8000_0001, 0, 8'd32, 1);
        apply(4'd5, 2'd0, 32'hA5, 0, 8'd9, 1);
        apply(4'd6, 2'd1, 32'h1234, 0, 8'd17, 0);
        apply(4'd1, 2'd0, 32'hFF, 0, 8'd12, 1);
        apply(4'd2, 2'd0, 32'h80, 0, 8'd31, 0);
        apply(4'd12, 2'd2, 32'hDEAD_BEEF, 0, 8'd5, 1);
        apply(4'd3, 2'd3, 32'hF0F0_0001, 0, 8'd33, 0);
        // swept vectors over all codes, sizes and counts
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] c8 = (k % 3 == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 34));
            apply(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), $urandom, $urandom,
                  c8, 1'($urandom_range(0, 1)));
        end
        @(negedge clk);
        if (pend) compare();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule